// File: doc/BRIEF.md
# Programmable PLL Reference Predivider

This block sits between a reference clock and the phase comparator of a PLL. It divides the reference by a ratio taken from a 5-bit control field. For field values from 4 to 31 the divided clock has a period of exactly that many reference cycles. The small field values have special meanings. Zero and one pass the reference straight through. Two halves it. Three is raised to the smallest normal ratio, four.

The field may change at any time. The block samples it only at the boundary between two output periods, so a period that has started always runs to its full length with the ratio it began with. A one-cycle marker pulse flags the reference cycle that opens each output period. In bypass the marker stays high on every cycle. The control field and the marker are plain level pins. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `ref_prediv`

## Requirements
- R1: While `rst_n` is low, `clk_div` and `period_mark` are both held low.
- R2: With a field value of 0 or 1 the block is in bypass. `clk_div` follows `clk_ref`, and `period_mark` is high on every reference cycle.
- R3: A field value of 2 gives an output period of 2 reference cycles: 1 cycle high, then 1 cycle low.
- R4: A field value of 3 gives the same output as a value of 4: a period of 4 cycles, high for 2.
- R5: A field value N from 4 to 31 gives an output period of N reference cycles. The output is high for the first floor(N/2) cycles and low for the rest.
- R6: Outside bypass, `period_mark` is high for exactly one reference cycle per output period. That cycle is the first high cycle of `clk_div`.
- R7: A change of the field never alters the period in progress. The new ratio applies from the next period boundary onward.
- R8: The first output period after reset is released uses the field value present at the first rising edge of `clk_ref`. That period begins at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_sel | input | 5 | Division field: 0/1 bypass, 2 halve, 3 treated as 4, 4..31 divide by the value |
| clk_div | output | 1 | Divided clock (the reference itself in bypass) |
| period_mark | output | 1 | High for the reference cycle that opens each output period |

## Verification
The bench measures whole output periods and counts high cycles for every field value from 0 to 31. A design that mapped 3 to a period of 3 would be caught, and so would one that treated 0 as a divider or rounded the high time the wrong way. Field changes are injected at random points inside running periods. A block that reloaded its ratio at once would produce a truncated or stretched period, and that period would be reported against R7. Bypass is probed in both clock phases, because a registered pass-through would lag the reference. The cycle after reset is released is checked, because a block that started one cycle late would delay the first marker.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_HALF   = 2'd1,
    MODE_DIV    = 2'd2
  } pdiv_mode_e;
endpackage

// File: rtl/pdiv_ratio_map.sv
module pdiv_ratio_map
  import pdiv_pkg::*;
#(
  parameter int unsigned SEL_W   = 5,
  parameter int unsigned MIN_DIV = 4
) (
  input  logic [SEL_W-1:0] sel,
  output logic [SEL_W-1:0] ratio,
  output pdiv_mode_e       mode
);
  localparam logic [SEL_W-1:0] ONE  = SEL_W'(1);
  localparam logic [SEL_W-1:0] TWO  = SEL_W'(2);
  localparam logic [SEL_W-1:0] MINR = SEL_W'(MIN_DIV);

  // Field codes at or below one bypass; two halves; anything else under
  // the minimum normal ratio is raised to that minimum.
  always_comb begin
    if (sel <= ONE) begin
      ratio = ONE;
      mode  = MODE_BYPASS;
    end else if (sel == TWO) begin
      ratio = TWO;
      mode  = MODE_HALF;
    end else if (sel < MINR) begin
      ratio = MINR;
      mode  = MODE_DIV;
    end else begin
      ratio = sel;
      mode  = MODE_DIV;
    end
  end
endmodule

// File: rtl/pdiv_phase.sv
module pdiv_phase
  import pdiv_pkg::*;
#(
  parameter int unsigned SEL_W   = 5,
  parameter int unsigned MIN_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] req_ratio,
  input  pdiv_mode_e       req_mode,
  output logic [SEL_W-1:0] nxt_cnt,
  output logic [SEL_W-1:0] nxt_ratio,
  output pdiv_mode_e       nxt_mode
);
  localparam logic [SEL_W-1:0] ONE = SEL_W'(1);

  logic [SEL_W-1:0] cnt_q;
  logic [SEL_W-1:0] ratio_q;
  pdiv_mode_e       mode_q;
  logic             wrap;

  // Reset leaves a ratio of one with the counter at zero, so the first
  // edge is a boundary and picks up the field (R8).
  assign wrap = (cnt_q == ratio_q - ONE);

  always_comb begin
    if (wrap) begin
      nxt_cnt   = '0;
      nxt_ratio = req_ratio;
      nxt_mode  = req_mode;
    end else begin
      nxt_cnt   = cnt_q + ONE;
      nxt_ratio = ratio_q;
      nxt_mode  = mode_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= ONE;
      mode_q  <= MODE_BYPASS;
    end else begin
      cnt_q   <= nxt_cnt;
      ratio_q <= nxt_ratio;
      mode_q  <= nxt_mode;
    end
  end

  p_cnt_in_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);

  p_ratio_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(ratio_q));

  p_div_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DIV) |-> (ratio_q >= SEL_W'(MIN_DIV)));
endmodule

// File: rtl/pdiv_shape.sv
module pdiv_shape
  import pdiv_pkg::*;
#(
  parameter int unsigned SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] nxt_cnt,
  input  logic [SEL_W-1:0] nxt_ratio,
  input  pdiv_mode_e       nxt_mode,
  output logic             clk_div,
  output logic             mark
);
  logic div_q;
  logic mark_q;
  logic byp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= 1'b0;
      mark_q <= 1'b0;
      byp_q  <= 1'b0;
    end else begin
      div_q  <= (nxt_cnt < (nxt_ratio >> 1));
      mark_q <= (nxt_cnt == '0);
      byp_q  <= (nxt_mode == MODE_BYPASS);
    end
  end

  // Bypass steers the reference itself onto the output.
  assign clk_div = byp_q ? clk : div_q;
  assign mark    = mark_q;

  p_rise_on_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_q) |-> mark_q);

  p_mark_high_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_q && !byp_q) |-> div_q);

  p_bypass_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byp_q |-> mark_q);
endmodule

// File: rtl/ref_prediv.sv
module ref_prediv #(
  parameter int unsigned SEL_W   = 5,
  parameter int unsigned MIN_DIV = 4
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             clk_div,
  output logic             period_mark
);
  import pdiv_pkg::*;

  logic [SEL_W-1:0] req_ratio;
  pdiv_mode_e       req_mode;
  logic [SEL_W-1:0] nxt_cnt;
  logic [SEL_W-1:0] nxt_ratio;
  pdiv_mode_e       nxt_mode;

  pdiv_ratio_map #(.SEL_W(SEL_W), .MIN_DIV(MIN_DIV)) u_map (
    .sel   (ratio_sel),
    .ratio (req_ratio),
    .mode  (req_mode)
  );

  pdiv_phase #(.SEL_W(SEL_W), .MIN_DIV(MIN_DIV)) u_phase (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .req_ratio (req_ratio),
    .req_mode  (req_mode),
    .nxt_cnt   (nxt_cnt),
    .nxt_ratio (nxt_ratio),
    .nxt_mode  (nxt_mode)
  );

  pdiv_shape #(.SEL_W(SEL_W)) u_shape (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .nxt_cnt   (nxt_cnt),
    .nxt_ratio (nxt_ratio),
    .nxt_mode  (nxt_mode),
    .clk_div   (clk_div),
    .mark      (period_mark)
  );
endmodule

// File: tb/ref_prediv_bench.sv
`timescale 1ns/1ps
module ref_prediv_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] field = 5'd10;
  logic       clk_div;
  logic       period_mark;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  ref_prediv u_ref_prediv (
    .clk_ref     (clk),
    .rst_n       (rst_n),
    .ratio_sel   (field),
    .clk_div     (clk_div),
    .period_mark (period_mark)
  );

  function automatic int eff(input int f);
    if (f <= 1) return 1;
    if (f == 2) return 2;
    if (f == 3) return 4;
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts at a negedge where period_mark is high; ends at the next such negedge.
  task automatic measure(input int chg_at, input logic [4:0] chg_val,
                         output int n, output int hi);
    n = 1;
    hi = int'(clk_div);
    forever begin
      if (n == chg_at) field = chg_val;
      @(negedge clk);
      if (period_mark) break;
      n++;
      hi += int'(clk_div);
      if (n > 70) break;
    end
  endtask

  task automatic wait_mark();
    int k = 0;
    @(negedge clk);
    while (!period_mark && k < 70) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, hi, cur, nf, off;
    void'($urandom(32'd4931));
    // R1: outputs low in both clock phases during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(clk_div == 1'b0 && period_mark == 1'b0, "R1 low phase", int'({clk_div, period_mark}), 0);
      @(posedge clk); #5;
      chk(clk_div == 1'b0 && period_mark == 1'b0, "R1 high phase", int'({clk_div, period_mark}), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R8: the first edge opens a period with the field then present
    @(negedge clk);
    chk(period_mark == 1'b1, "R8 first mark", int'(period_mark), 1);
    measure(0, 5'd0, n, hi);
    chk(n == 10, "R8 first period", n, 10);
    chk(hi == 5, "R8 first high", hi, 5);
    cur = 10;

    // Directed sweep of all field values
    for (int f = 0; f < 32; f++) begin
      field = 5'(f);
      measure(0, 5'd0, n, hi);
      chk(n == cur, "R7 old period kept", n, cur);
      cur = eff(f);
      if (cur == 1) begin
        chk(period_mark == 1'b1 && clk_div == 1'b0, "R2 bypass low phase", int'({clk_div, period_mark}), 1);
        @(posedge clk); #5;
        chk(clk_div == 1'b1, "R2 bypass follows ref", int'(clk_div), 1);
        @(negedge clk);
        chk(period_mark == 1'b1, "R2 mark every cycle", int'(period_mark), 1);
      end else begin
        chk(clk_div == 1'b1, "R6 mark in high phase", int'(clk_div), 1);
      end
      measure(0, 5'd0, n, hi);
      if (f == 2) begin
        chk(n == 2, "R3 period", n, 2);
        chk(hi == 1, "R3 high", hi, 1);
      end else if (f == 3) begin
        chk(n == 4, "R4 period", n, 4);
        chk(hi == 2, "R4 high", hi, 2);
      end else if (f >= 4) begin
        chk(n == f, "R5 period", n, f);
        chk(hi == f / 2, "R5 high", hi, f / 2);
      end else begin
        chk(n == 1, "R2 bypass period", n, 1);
      end
    end

    // Random mid-period changes
    for (int it = 0; it < 60; it++) begin
      nf = int'($urandom_range(31, 0));
      off = (cur > 1) ? int'($urandom_range(cur - 1, 1)) : 1;
      if (cur == 1) field = 5'(nf);
      measure(off, 5'(nf), n, hi);
      chk(n == cur, "R7 change mid period", n, cur);
      cur = eff(nf);
      measure(0, 5'd0, n, hi);
      chk(n == cur, "R5 random period", n, cur);
      if (cur > 1) chk(hi == cur / 2, "R6 random high", hi, cur / 2);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule